// File: doc/BRIEF.md
# Halfword Load Data Alignment Unit

This unit formats the data of a halfword or signed-byte load before write-back in a 32-bit load/store pipeline. The memory side always returns the 16-bit halfword at the address with bit 0 cleared. The unit uses the low address bit, a two-bit load-kind code and a one-bit architecture-mode select to build the 32-bit value for the destination register.

The two modes differ only on misaligned (odd) halfword loads. In legacy mode, an odd unsigned halfword load is rotated, and an odd signed halfword load sign-extends only its upper byte. In the newer mode, both halfword kinds ignore the low address bit and read the aligned halfword. The mode bit is sampled with each load, and no earlier load affects a later one.

A parameter adds an output register with a load-valid enable. With the register in place, the result appears one clock after the load is presented.

Top module: `hwld_align`

## Requirements
- R1: The load kind is encoded as 2'b01 unsigned halfword, 2'b10 signed byte and 2'b11 signed halfword. Code 2'b00 must never arrive with `ld_valid` high.
- R2: In legacy mode (`arch_new`=0), an unsigned halfword load zero-extends `mem_half`. At an odd address, that value is rotated right by 8 bits, so the result is {mem_half[7:0], 16'h0000, mem_half[15:8]}.
- R3: In newer mode (`arch_new`=1), an unsigned halfword load returns {16'h0000, mem_half} for either address parity.
- R4: In legacy mode, a signed halfword load at an even address sign-extends all 16 bits of `mem_half` from bit 15.
- R5: In legacy mode, a signed halfword load at an odd address sign-extends `mem_half[15:8]` from bit 15 of `mem_half`.
- R6: In newer mode, a signed halfword load sign-extends all 16 bits of `mem_half`, ignoring `addr_lsb`.
- R7: A signed byte load selects `mem_half[15:8]` when `addr_lsb`=1 and `mem_half[7:0]` otherwise, then sign-extends that byte to 32 bits. This holds in both modes.
- R8: The mode applies to each load on its own. Toggling `arch_new` between back-to-back loads with otherwise identical inputs gives each load the result of its own mode.
- R9: With the output register enabled, a load presented with `ld_valid`=1 appears on `wb_data` after the next rising clock edge. `wb_valid` is `ld_valid` delayed by one cycle.
- R10: While `ld_valid`=0, `wb_data` keeps its previous value, whatever the other inputs do.
- R11: While `rst_n` is low, `wb_data` and `wb_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load result is presented this cycle |
| ld_kind | input | 2 | Load kind: 01 unsigned half, 10 signed byte, 11 signed half |
| arch_new | input | 1 | 0 selects legacy misalignment handling, 1 selects forced alignment |
| addr_lsb | input | 1 | Bit 0 of the load address |
| mem_half | input | 16 | Halfword read from the address with bit 0 cleared |
| wb_valid | output | 1 | Write-back data valid |
| wb_data | output | 32 | Formatted value for the destination register |

## Verification
Any fault in the lane selection or extension logic shows on `wb_data` one cycle after the faulty load is accepted. Such faults are easiest to expose with sign-boundary halfwords, where a wrong lane or a wrong sign bit changes the upper 24 bits. A fault in the output register's enable shows in the first idle cycle, when `wb_data` moves although it should hold. A mode value left over from an earlier load shows on the next load only when the mode has changed, so the bench alternates the mode on back-to-back loads.

// File: rtl/hwld_pkg.sv
package hwld_pkg;
  typedef enum logic [1:0] {
    LK_RSVD  = 2'b00,
    LK_UHALF = 2'b01,
    LK_SBYTE = 2'b10,
    LK_SHALF = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/hwld_lane_pick.sv
module hwld_lane_pick #(
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic              lsb_i,
  output logic [BYTE_W-1:0] lo_byte_o,
  output logic [BYTE_W-1:0] hi_byte_o,
  output logic [BYTE_W-1:0] sel_byte_o
);
  always_comb begin
    lo_byte_o  = half_i[BYTE_W-1:0];
    hi_byte_o  = half_i[HALF_W-1:BYTE_W];
    sel_byte_o = lsb_i ? hi_byte_o : lo_byte_o;
  end
endmodule

// File: rtl/hwld_extend.sv
module hwld_extend
  import hwld_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2
) (
  input  ld_kind_e          kind_i,
  input  logic              arch_new_i,
  input  logic              lsb_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [BYTE_W-1:0] hi_byte_i,
  input  logic [BYTE_W-1:0] sel_byte_i,
  output logic [DATA_W-1:0] fmt_o
);
  logic [DATA_W-1:0] zx_half;
  logic [DATA_W-1:0] sx_half;
  logic [DATA_W-1:0] sx_hi;
  logic [DATA_W-1:0] sx_sel;
  logic              misaligned_legacy;

  always_comb begin
    zx_half = {{(DATA_W-HALF_W){1'b0}}, half_i};
    sx_half = {{(DATA_W-HALF_W){half_i[HALF_W-1]}}, half_i};
    sx_hi   = {{(DATA_W-BYTE_W){hi_byte_i[BYTE_W-1]}}, hi_byte_i};
    sx_sel  = {{(DATA_W-BYTE_W){sel_byte_i[BYTE_W-1]}}, sel_byte_i};
    misaligned_legacy = lsb_i && !arch_new_i;
  end

  always_comb begin
    unique case (kind_i)
      LK_UHALF: fmt_o = misaligned_legacy ?
                        {zx_half[BYTE_W-1:0], zx_half[DATA_W-1:BYTE_W]} : zx_half;
      LK_SBYTE: fmt_o = sx_sel;
      LK_SHALF: fmt_o = misaligned_legacy ? sx_hi : sx_half;
      default:  fmt_o = '0;
    endcase
  end
endmodule

// File: rtl/hwld_out_stage.sv
module hwld_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] data_d, data_q;
      logic              vld_q;

      always_comb begin
        data_d = vld_i ? data_i : data_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          data_q <= data_d;
          vld_q  <= vld_i;
        end
      end

      assign data_o = data_q;
      assign vld_o  = vld_q;

      // R9
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (data_o == $past(data_i)) && vld_o);
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(data_o) && !vld_o);
    end else begin : g_comb
      assign data_o = data_i;
      assign vld_o  = vld_i;
    end
  endgenerate
endmodule

// File: rtl/hwld_align.sv
module hwld_align
  import hwld_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int BYTE_W = HALF_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [1:0]        ld_kind,
  input  logic              arch_new,
  input  logic              addr_lsb,
  input  logic [HALF_W-1:0] mem_half,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data
);
  ld_kind_e          kind;
  logic [BYTE_W-1:0] lo_byte, hi_byte, sel_byte;
  logic [DATA_W-1:0] fmt;

  assign kind = ld_kind_e'(ld_kind);

  hwld_lane_pick #(.HALF_W(HALF_W)) u_pick (
    .half_i     (mem_half),
    .lsb_i      (addr_lsb),
    .lo_byte_o  (lo_byte),
    .hi_byte_o  (hi_byte),
    .sel_byte_o (sel_byte)
  );

  hwld_extend #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_ext (
    .kind_i     (kind),
    .arch_new_i (arch_new),
    .lsb_i      (addr_lsb),
    .half_i     (mem_half),
    .hi_byte_i  (hi_byte),
    .sel_byte_i (sel_byte),
    .fmt_o      (fmt)
  );

  hwld_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (ld_valid),
    .data_i (fmt),
    .vld_o  (wb_valid),
    .data_o (wb_data)
  );

  // R1
  illegal_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (ld_kind != 2'b00));
  // R7
  sbyte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_kind == 2'b10) |->
      (fmt[BYTE_W-1:0] == (addr_lsb ? mem_half[HALF_W-1:BYTE_W] : mem_half[BYTE_W-1:0])));
  // R3
  new_uhalf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && arch_new && ld_kind == 2'b01) |->
      (fmt == {{(DATA_W-HALF_W){1'b0}}, mem_half}));
  // R6
  new_shalf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && arch_new && ld_kind == 2'b11) |->
      (fmt[HALF_W-1:0] == mem_half && fmt[DATA_W-1] == mem_half[HALF_W-1]));
  // R5
  legacy_odd_shalf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !arch_new && addr_lsb && ld_kind == 2'b11) |->
      (fmt[BYTE_W-1:0] == mem_half[HALF_W-1:BYTE_W] && fmt[DATA_W-1] == mem_half[HALF_W-1]));
endmodule

// File: tb/test_hwld_align.sv
module test_hwld_align;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic [1:0]  ld_kind;
  logic        arch_new;
  logic        addr_lsb;
  logic [15:0] mem_half;
  logic        wb_valid;
  logic [31:0] wb_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_data;

  always #(CLK_P/2) clk = ~clk;

  hwld_align i_hwld_align (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_kind(ld_kind),
    .arch_new(arch_new), .addr_lsb(addr_lsb), .mem_half(mem_half),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  function automatic logic [31:0] model(logic [1:0] k, logic lsb, logic nw, logic [15:0] h);
    case (k)
      2'b01: return (!nw && lsb) ? {h[7:0], 16'h0000, h[15:8]} : {16'h0000, h};
      2'b10: return lsb ? {{24{h[15]}}, h[15:8]} : {{24{h[7]}}, h[7:0]};
      2'b11: return (!nw && lsb) ? {{24{h[15]}}, h[15:8]} : {{16{h[15]}}, h};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] k, logic lsb, logic nw);
    if (k == 2'b10) return "R7";
    if (k == 2'b01) return nw ? "R3" : "R2";
    if (nw) return "R6";
    return lsb ? "R5" : "R4";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [1:0] k, logic lsb, logic nw, logic [15:0] h, string tag);
    @(negedge clk);
    ld_valid = v; ld_kind = k; addr_lsb = lsb; arch_new = nw; mem_half = h;
    @(posedge clk);
    #1;
    if (v) exp_data = model(k, lsb, nw, h);
    check(v ? tag : "R10", wb_data, exp_data);
    check("R9", {31'h0, wb_valid}, {31'h0, v});
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] corners [6];
    corners = '{16'h007F, 16'h0080, 16'h7FFF, 16'h8000, 16'h80FF, 16'h7F80};
    void'($urandom(32'd2024));
    rst_n = 1'b0; ld_valid = 1'b0; ld_kind = 2'b01; arch_new = 1'b0;
    addr_lsb = 1'b0; mem_half = 16'h0;
    exp_data = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", wb_data, 32'h0);
    check("R11", {31'h0, wb_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed sign-boundary corners: R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 6; c++)
      for (int k = 1; k < 4; k++)
        for (int m = 0; m < 2; m++)
          for (int l = 0; l < 2; l++)
            step(1'b1, 2'(k), 1'(l), 1'(m), corners[c], req_of(2'(k), 1'(l), 1'(m)));

    // R8: toggle mode between back-to-back loads with identical inputs
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 2'b01, 1'b1, 1'(i % 2), 16'hA55A, "R8");
      step(1'b1, 2'b11, 1'b1, 1'(i % 2), 16'h8C01, "R8");
    end

    // R10: idle cycles with changing inputs hold output
    for (int i = 0; i < 6; i++)
      step(1'b0, 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), "R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic        v;
      logic [1:0]  k;
      logic        l, m;
      v = ($urandom % 4) != 0;
      k = 2'(($urandom % 3) + 1);
      if (!v) k = 2'($urandom);
      l = 1'($urandom);
      m = 1'($urandom);
      step(v, k, l, m, 16'($urandom), req_of(k, l, m));
    end

    // R11: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11", wb_data, 32'h0);
    check("R11", {31'h0, wb_valid}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule